// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Indexed Register Window

This block is a core-local interrupt controller. It watches a parameterized group of level-sensitive interrupt lines and presents to the processor at most one request at a time, together with the number of the line that should be served. Line numbers are offset by sixteen, since numbers 0 to 15 are kept for exceptions: line k is known to software as number 16+k.

Each line carries an enable bit and a priority. Software does not reach these through a flat map. It first writes a line number into a select register, and later accesses to the priority and enable registers then act on that line. A read-only configuration word describes the build: version, line count, count of external lines, number of priority levels (stored as levels minus one) and a fast-interrupt flag. The processor's status word arrives as an input and supplies a global enable bit and a priority threshold. A request goes out only for a line that is asserted, enabled, and more urgent than the threshold.

The register port is a single-cycle write strobe with an address, and the read data is a combinational function of the address and the current state.

Top module: `intc_core`

## Requirements
- R1: After reset every line is enabled, every priority equals NUM_LEVELS-1, the select register reads 0 and no request is raised.
- R2: Register address 3 reads the configuration word: bits [7:0] VERSION, [15:8] NUM_LINES, [23:16] NUM_LINES-NUM_PRIVATE, [27:24] NUM_LEVELS-1, bit 28 FAST_IRQ and bits [31:29] zero.
- R3: A write to address 0 stores reg_wdata[7:0] as the select value. A read of address 0 returns it zero-extended.
- R4: With a line number 16+k selected, writing address 2 stores reg_wdata[0] as the enable of line k (0 masks, 1 unmasks). A read returns that enable in bit 0 and zeros above it.
- R5: With a line number 16+k selected, writing address 1 stores the low log2(NUM_LEVELS) bits of reg_wdata as the priority of line k and drops the upper bits. A read returns the stored priority zero-extended.
- R6: When the select value is below 16 or at or above 16+NUM_LINES, writes to addresses 1 and 2 change no line's state, and reads of addresses 1 and 2 return 0.
- R7: irq_req is 1 only if status_word[31] (global enable) is 1 and at least one line k is high, enabled, and has a priority numerically below the threshold in status_word[4:1].
- R8: When irq_req is 1, irq_num is 16+k for the qualifying line with the lowest priority value, the lowest k winning a tie. When irq_req is 0, irq_num is 0.
- R9: A change on irq_lines or status_word affects irq_req and irq_num in the same cycle. A register write affects them from the clock edge that takes the write.
- R10: Writes to address 3 are ignored: the configuration word reads back unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | NUM_LINES | Level-sensitive interrupt lines, bit k is number 16+k |
| status_word | input | 32 | Processor status: bit 31 global enable, bits [4:1] threshold |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 select, 1 priority, 2 enable, 3 configuration |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| irq_req | output | 1 | Interrupt request to the processor |
| irq_num | output | 8 | Number of the winning line, 0 when idle |

## Verification
The hardest situation to reach from the ports is a tie at the best priority among several qualifying lines while a higher line has a better priority but is masked. The window makes every such setup a series of select-then-write pairs. The stimulus first moves chosen lines to shared priorities, masks the better one, and later unmasks it, so the winner changes at a known edge. A long random phase then mixes out-of-range selects with priority and enable writes, line toggles and threshold changes. It is checked against a behavioural model every cycle, which catches any alias of an out-of-range select onto a real line.

// File: rtl/ictl_pkg.sv
package ictl_pkg;

    localparam int unsigned EXC_SLOTS = 16;

    typedef enum logic [1:0] {
        ADDR_SEL  = 2'd0,
        ADDR_PRIO = 2'd1,
        ADDR_EN   = 2'd2,
        ADDR_CFG  = 2'd3
    } reg_addr_e;

    function automatic logic [31:0] build_cfg(
        input logic [7:0] ver,
        input logic [7:0] lines,
        input logic [7:0] ext_lines,
        input logic [3:0] lvl_m1,
        input logic       fast
    );
        return {3'b000, fast, lvl_m1, ext_lines, lines, ver};
    endfunction

endpackage

// File: rtl/ictl_regs.sv
module ictl_regs
    import ictl_pkg::*;
#(
    parameter int unsigned NUM_LINES  = 16,
    parameter int unsigned NUM_LEVELS = 4,
    parameter int unsigned SEL_W      = 8,
    localparam int unsigned PRIO_W    = (NUM_LEVELS > 1) ? $clog2(NUM_LEVELS) : 1,
    localparam int unsigned IDX_W     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              we,
    input  logic [1:0]                        addr,
    input  logic [31:0]                       wdata,
    output logic [SEL_W-1:0]                  sel,
    output logic [NUM_LINES-1:0][PRIO_W-1:0]  prio,
    output logic [NUM_LINES-1:0]              en,
    output logic [31:0]                       rdata
);

    localparam logic [PRIO_W-1:0] PRIO_RST = PRIO_W'(NUM_LEVELS - 1);

    typedef struct packed {
        logic [SEL_W-1:0]                 sel;
        logic [NUM_LINES-1:0][PRIO_W-1:0] prio;
        logic [NUM_LINES-1:0]             en;
    } regs_t;

    regs_t            r_d, r_q;
    logic             in_range;
    logic [IDX_W-1:0] idx;

    always_comb begin
        in_range = (32'(r_q.sel) >= 32'(EXC_SLOTS)) &&
                   (32'(r_q.sel) < 32'(EXC_SLOTS + NUM_LINES));
        idx      = IDX_W'(r_q.sel - SEL_W'(EXC_SLOTS));

        r_d = r_q;
        if (we) begin
            case (addr)
                ADDR_SEL:  r_d.sel = wdata[SEL_W-1:0];
                ADDR_PRIO: if (in_range) r_d.prio[idx] = wdata[PRIO_W-1:0];
                ADDR_EN:   if (in_range) r_d.en[idx]   = wdata[0];
                default:   ;
            endcase
        end

        case (addr)
            ADDR_SEL:  rdata = 32'(r_q.sel);
            ADDR_PRIO: rdata = in_range ? 32'(r_q.prio[idx]) : 32'd0;
            ADDR_EN:   rdata = in_range ? 32'(r_q.en[idx])   : 32'd0;
            default:   rdata = 32'd0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.sel  <= '0;
            r_q.prio <= {NUM_LINES{PRIO_RST}};
            r_q.en   <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    assign sel  = r_q.sel;
    assign prio = r_q.prio;
    assign en   = r_q.en;

endmodule

// File: rtl/ictl_qual.sv
module ictl_qual #(
    parameter int unsigned NUM_LINES = 16,
    parameter int unsigned PRIO_W    = 2
) (
    input  logic [NUM_LINES-1:0]             lines,
    input  logic [NUM_LINES-1:0]             en,
    input  logic [NUM_LINES-1:0][PRIO_W-1:0] prio,
    input  logic                             glob_en,
    input  logic [3:0]                       thresh,
    output logic [NUM_LINES-1:0]             qual
);

    for (genvar k = 0; k < NUM_LINES; k++) begin : g_line
        assign qual[k] = glob_en && lines[k] && en[k] &&
                         (32'(prio[k]) < 32'(thresh));
    end

endmodule

// File: rtl/ictl_arb.sv
module ictl_arb #(
    parameter int unsigned NUM_LINES = 16,
    parameter int unsigned PRIO_W    = 2,
    localparam int unsigned IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic [NUM_LINES-1:0]             qual,
    input  logic [NUM_LINES-1:0][PRIO_W-1:0] prio,
    output logic                             found,
    output logic [IDX_W-1:0]                 win_idx
);

    logic [PRIO_W-1:0] best_p;

    always_comb begin
        found   = 1'b0;
        win_idx = '0;
        best_p  = '1;
        for (int k = 0; k < NUM_LINES; k++) begin
            if (qual[k] && (!found || (prio[k] < best_p))) begin
                found   = 1'b1;
                win_idx = IDX_W'(k);
                best_p  = prio[k];
            end
        end
    end

endmodule

// File: rtl/intc_core.sv
module intc_core
    import ictl_pkg::*;
#(
    parameter int unsigned NUM_LINES   = 16,
    parameter int unsigned NUM_LEVELS  = 4,
    parameter int unsigned NUM_PRIVATE = 8,
    parameter logic [7:0]  VERSION     = 8'h02,
    parameter logic        FAST_IRQ    = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_lines,
    input  logic [31:0]          status_word,
    input  logic                 reg_we,
    input  logic [1:0]           reg_addr,
    input  logic [31:0]          reg_wdata,
    output logic [31:0]          reg_rdata,
    output logic                 irq_req,
    output logic [7:0]           irq_num
);

    localparam int unsigned SEL_W  = 8;
    localparam int unsigned PRIO_W = (NUM_LEVELS > 1) ? $clog2(NUM_LEVELS) : 1;
    localparam int unsigned IDX_W  = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;
    localparam int unsigned IE_BIT = 31;
    localparam int unsigned TH_LSB = 1;
    localparam logic [31:0] CFG_WORD = build_cfg(VERSION, 8'(NUM_LINES),
                                                 8'(NUM_LINES - NUM_PRIVATE),
                                                 4'(NUM_LEVELS - 1), FAST_IRQ);

    logic [SEL_W-1:0]                 sel_cur;
    logic [NUM_LINES-1:0][PRIO_W-1:0] prio;
    logic [NUM_LINES-1:0]             en;
    logic [NUM_LINES-1:0]             qual;
    logic [31:0]                      win_rdata;
    logic                             found;
    logic [IDX_W-1:0]                 win_idx;
    logic                             unused_bits;

    assign unused_bits = ^{reg_wdata[31:SEL_W], status_word[30:5], status_word[0]};

    ictl_regs #(
        .NUM_LINES (NUM_LINES),
        .NUM_LEVELS(NUM_LEVELS),
        .SEL_W     (SEL_W)
    ) u_regs (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (reg_we),
        .addr (reg_addr),
        .wdata(reg_wdata),
        .sel  (sel_cur),
        .prio (prio),
        .en   (en),
        .rdata(win_rdata)
    );

    ictl_qual #(
        .NUM_LINES(NUM_LINES),
        .PRIO_W   (PRIO_W)
    ) u_qual (
        .lines  (irq_lines),
        .en     (en),
        .prio   (prio),
        .glob_en(status_word[IE_BIT]),
        .thresh (status_word[TH_LSB+3:TH_LSB]),
        .qual   (qual)
    );

    ictl_arb #(
        .NUM_LINES(NUM_LINES),
        .PRIO_W   (PRIO_W)
    ) u_arb (
        .qual   (qual),
        .prio   (prio),
        .found  (found),
        .win_idx(win_idx)
    );

    always_comb begin
        reg_rdata = (reg_addr == ADDR_CFG) ? CFG_WORD : win_rdata;
        irq_req   = found;
        irq_num   = found ? 8'(EXC_SLOTS + 32'(win_idx)) : 8'd0;
    end

endmodule

// File: rtl/intc_core_chk.sv
module intc_core_chk #(
    parameter int unsigned NUM_LINES = 16,
    localparam int unsigned IDX_W    = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_LINES-1:0] irq_lines,
    input logic [31:0]          status_word,
    input logic [1:0]           reg_addr,
    input logic [31:0]          reg_rdata,
    input logic                 irq_req,
    input logic [7:0]           irq_num,
    input logic [7:0]           sel_cur
);

    logic sel_ok;
    assign sel_ok = (32'(sel_cur) >= 32'd16) && (32'(sel_cur) < 32'(16 + NUM_LINES));

    AST_NUM_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (32'(irq_num) >= 32'd16) && (32'(irq_num) < 32'(16 + NUM_LINES))); // R8

    AST_IDLE_NUM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_req |-> (irq_num == 8'd0)); // R8

    AST_GLOBAL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !status_word[31] |-> !irq_req); // R7

    AST_WINNER_ASSERTED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> irq_lines[IDX_W'(irq_num - 8'd16)]); // R7

    AST_OOR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_ok && (reg_addr == 2'd1 || reg_addr == 2'd2)) |-> (reg_rdata == 32'd0)); // R6

    AST_CFG_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 2'd3 && $past(reg_addr) == 2'd3) |-> $stable(reg_rdata)); // R10

endmodule

bind intc_core intc_core_chk #(.NUM_LINES(NUM_LINES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq_lines  (irq_lines),
    .status_word(status_word),
    .reg_addr   (reg_addr),
    .reg_rdata  (reg_rdata),
    .irq_req    (irq_req),
    .irq_num    (irq_num),
    .sel_cur    (sel_cur)
);

// File: tb/intc_core_test.sv
module intc_core_test;

    localparam int N      = 16;
    localparam int LEVELS = 4;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] irq_lines = '0;
    logic [31:0]  status_word = '0;
    logic         reg_we = 1'b0;
    logic [1:0]   reg_addr = 2'd0;
    logic [31:0]  reg_wdata = '0;
    logic [31:0]  reg_rdata;
    logic         irq_req;
    logic [7:0]   irq_num;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  started = 0;
    bit  done = 0;

    int  m_prio [N];
    bit  m_en [N];
    int  m_sel;

    always #10 clk = ~clk;

    intc_core uut (
        .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .status_word(status_word),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_req(irq_req), .irq_num(irq_num)
    );

    function automatic logic [31:0] st(input bit ie, input int th);
        return {ie, 26'd0, 4'(th), 1'b0};
    endfunction

    function automatic bit sel_valid();
        return (m_sel >= 16) && (m_sel < 16 + N);
    endfunction

    // behavioural model of the register state
    always @(posedge clk) begin
        started <= 1;
        if (!rst_n) begin
            m_sel = 0;
            for (int k = 0; k < N; k++) begin
                m_prio[k] = LEVELS - 1;
                m_en[k]   = 1;
            end
        end else if (reg_we) begin
            case (reg_addr)
                2'd0: m_sel = int'(reg_wdata[7:0]);
                2'd1: if (sel_valid()) m_prio[m_sel-16] = int'(reg_wdata) % LEVELS;
                2'd2: if (sel_valid()) m_en[m_sel-16] = reg_wdata[0];
                default: ;
            endcase
        end
    end

    function automatic int model_num();
        int best = -1;
        int th = int'(status_word[4:1]);
        if (!status_word[31]) return 0;
        for (int k = 0; k < N; k++)
            if (irq_lines[k] && m_en[k] && m_prio[k] < th)
                if (best < 0 || m_prio[k] < m_prio[best]) best = k;
        return (best < 0) ? 0 : 16 + best;
    endfunction

    function automatic logic [31:0] model_rdata();
        case (reg_addr)
            2'd0:    return 32'(m_sel);
            2'd1:    return sel_valid() ? 32'(m_prio[m_sel-16]) : 32'd0;
            2'd2:    return sel_valid() ? 32'(m_en[m_sel-16]) : 32'd0;
            default: return 32'h0308_1002;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s at %0t: got %0h expected %0h", tag, $time, got, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (started && rst_n && !done) begin
            int en_num;
            en_num = model_num();
            chk("R7 irq_req", 32'(irq_req), 32'(en_num != 0));
            chk("R8 irq_num", 32'(irq_num), 32'(en_num));
            case (reg_addr)
                2'd0:    chk("R3 select read", reg_rdata, model_rdata());
                2'd1:    chk(sel_valid() ? "R5 prio read" : "R6 prio read", reg_rdata, model_rdata());
                2'd2:    chk(sel_valid() ? "R4 enable read" : "R6 enable read", reg_rdata, model_rdata());
                default: chk("R2 config read", reg_rdata, model_rdata());
            endcase
        end
    end

    task automatic cyc(input bit we, input logic [1:0] a, input logic [31:0] d);
        @(posedge clk);
        #5;
        reg_we = we; reg_addr = a; reg_wdata = d;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        cyc(1'b1, a, d);
        cyc(1'b0, a, 32'd0);
    endtask

    task automatic rd(input logic [1:0] a);
        cyc(1'b0, a, 32'd0);
        @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #5 rst_n = 1'b1;

        // R1: reset state
        rd(2'd0);
        chk("R1 select after reset", reg_rdata, 32'd0);
        chk("R1 no request after reset", 32'(irq_req), 32'd0);
        wr(2'd0, 32'd16);
        rd(2'd1);
        chk("R1 reset priority", reg_rdata, 32'd3);
        rd(2'd2);
        chk("R1 reset enable", reg_rdata, 32'd1);

        // R2 / R10: configuration word
        rd(2'd3);
        chk("R2 config word", reg_rdata, 32'h0308_1002);
        wr(2'd3, 32'hFFFF_FFFF);
        rd(2'd3);
        chk("R10 config unchanged", reg_rdata, 32'h0308_1002);

        // R7 / R9: single line, enable and threshold gating
        cyc(1'b0, 2'd0, 32'd0);
        irq_lines = 16'h0020;
        status_word = st(1, 4);
        @(negedge clk);
        chk("R9 same-cycle request", 32'(irq_req), 32'd1);
        chk("R8 single line number", 32'(irq_num), 32'd21);
        cyc(1'b0, 2'd0, 32'd0);
        status_word = st(0, 4);
        @(negedge clk);
        chk("R7 global enable off", 32'(irq_req), 32'd0);
        cyc(1'b0, 2'd0, 32'd0);
        status_word = st(1, 3);
        @(negedge clk);
        chk("R7 threshold blocks", 32'(irq_req), 32'd0);

        // R8: tie-break and best priority
        status_word = st(1, 4);
        wr(2'd0, 32'd25); wr(2'd1, 32'd1);
        wr(2'd0, 32'd20); wr(2'd1, 32'd1);
        irq_lines = 16'h0230;
        @(negedge clk);
        chk("R8 tie lowest number", 32'(irq_num), 32'd20);
        wr(2'd0, 32'd25); wr(2'd1, 32'd0);
        @(negedge clk);
        chk("R8 best priority wins", 32'(irq_num), 32'd25);

        // R4 / R9: masking takes effect from the write edge
        cyc(1'b1, 2'd2, 32'd0);
        @(negedge clk);
        chk("R9 before write edge", 32'(irq_num), 32'd25);
        cyc(1'b0, 2'd2, 32'd0);
        @(negedge clk);
        chk("R4 masked line skipped", 32'(irq_num), 32'd20);
        chk("R4 enable reads 0", reg_rdata, 32'd0);
        wr(2'd2, 32'd1);
        @(negedge clk);
        chk("R4 unmask restores", 32'(irq_num), 32'd25);

        // R5: priority truncation
        wr(2'd0, 32'd18); wr(2'd1, 32'hFF);
        rd(2'd1);
        chk("R5 truncated to 3", reg_rdata, 32'd3);
        wr(2'd1, 32'd6);
        rd(2'd1);
        chk("R5 truncated to 2", reg_rdata, 32'd2);

        // R6: out-of-range selects
        wr(2'd0, 32'd15); wr(2'd1, 32'd0); wr(2'd2, 32'd0);
        rd(2'd1);
        chk("R6 low select prio read", reg_rdata, 32'd0);
        rd(2'd2);
        chk("R6 low select enable read", reg_rdata, 32'd0);
        wr(2'd0, 32'd32); wr(2'd1, 32'd0); wr(2'd2, 32'd0);
        rd(2'd2);
        chk("R6 high select enable read", reg_rdata, 32'd0);
        wr(2'd0, 32'd31);
        rd(2'd1);
        chk("R6 line 31 prio untouched", reg_rdata, 32'd3);
        rd(2'd2);
        chk("R6 line 31 enable untouched", reg_rdata, 32'd1);
        wr(2'd0, 32'd16);
        rd(2'd1);
        chk("R6 line 16 prio untouched", reg_rdata, 32'd3);
        rd(2'd2);
        chk("R6 line 16 enable untouched", reg_rdata, 32'd1);

        // R3: select readback of a wide value
        wr(2'd0, 32'h1234_56C3);
        rd(2'd0);
        chk("R3 select low byte", reg_rdata, 32'h0000_00C3);

        // random phase, checked each cycle by the model
        for (int i = 0; i < 2000; i++) begin
            int pick;
            pick = int'($urandom_range(0, 9));
            if (pick < 2)
                cyc(1'b1, 2'd0, 32'($urandom_range(12, 35)));
            else if (pick < 4)
                cyc(1'b1, 2'd1, 32'($urandom_range(0, 255)));
            else if (pick < 6)
                cyc(1'b1, 2'd2, 32'($urandom_range(0, 3)));
            else
                cyc(1'b0, 2'($urandom_range(0, 3)), 32'($urandom));
            if (pick == 7) irq_lines = N'($urandom);
            if (pick == 8) status_word = st($urandom_range(0, 7) != 0, int'($urandom_range(0, 5)));
        end
        cyc(1'b0, 2'd0, 32'd0);
        @(negedge clk);
        finish_run();
    end

endmodule